// File: doc/BRIEF.md
# Two-Frame Doorbell Mailbox

This block lets one processor ring doorbells at another. It holds a small array of channels, and each channel is a single 32-bit status word. Two register frames look onto the same words. The sender frame posts doorbells by setting bits, and the receiver frame consumes them by clearing bits. A bit is a pending doorbell for as long as it stays 1. The sender knows a message was taken once the channel status reads back as zero.

The sender may not post before it owns the mailbox. It raises a one-bit access request, and a delayed access-ready flag answers it. Set writes that arrive while the flag is low are dropped. The receiver gets one interrupt line per channel. It also gets an optional combined line, which exists only when the identification register reports minor revision 1. Both frames are simple single-cycle register ports: a select, a write strobe, a byte address, write data and combinational read data.

Top module: `dbell_mbox`

## Requirements
- R1: A sender-frame write to channel n offset 0xC (channel n window at byte address n*0x20) while access-ready is high ORs the write data into status word n on that clock edge.
- R2: A write to channel n offset 0x8 from either frame clears every status bit that is 1 in the write data. When a set and a clear reach the same word in one cycle, the set bits win.
- R3: Offset 0x0 of channel n reads status word n, and both frames return the identical word.
- R4: irq_ch[n] is high exactly while status word n is nonzero. It follows the word with no added register.
- R5: Bit 2 of receiver-frame address 0xF98 is the combined-interrupt enable, and the other bits read zero. The bit is writable only when REV_MINOR is 1. irq_any is high exactly while the enable is 1 and any status word is nonzero.
- R6: Sender-frame address 0xF88 bit 0 is the read/write access request. Address 0xF8C bit 0 reads access-ready, which takes the request's value two clock edges after the request changes, in both directions.
- R7: Sender set writes made while access-ready is low leave the status word unchanged.
- R8: Sender address 0xF80 reads NCH (default 4, nonzero and even). Address 0xFCC in both frames reads ID_MAJOR in bits 7:4 and REV_MINOR in bits 3:0 (defaults 2 and 1, giving 0x21). Writes to these addresses change nothing.
- R9: Every other address reads zero, and writes to it change nothing. This includes receiver-frame offset 0xC, receiver address 0xF80/0xF88/0xF8C, and sender address 0xF98.
- R10: After reset, all status words, the access request, access-ready and the combined enable are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_sel | input | 1 | Sender frame access strobe |
| s_wr | input | 1 | Sender frame write (1) or read (0) |
| s_addr | input | AW | Sender frame byte address |
| s_wdata | input | DW | Sender frame write data |
| s_rdata | output | DW | Sender frame read data, combinational |
| r_sel | input | 1 | Receiver frame access strobe |
| r_wr | input | 1 | Receiver frame write (1) or read (0) |
| r_addr | input | AW | Receiver frame byte address |
| r_wdata | input | DW | Receiver frame write data |
| r_rdata | output | DW | Receiver frame read data, combinational |
| irq_ch | output | NCH | Per-channel interrupt, high while the channel is nonzero |
| irq_any | output | 1 | Combined interrupt |

## Verification
Doorbells are posted as single bits, as multi-bit masks and as the top bit of the last channel. Together these show whether the set merges into the word or replaces it, and whether the channel window is decoded correctly. Clears come from each frame separately, and then a set and a clear are aimed at one word in the same cycle, which shows the merge priority. The access request is toggled and read on every cycle, so a ready that arrives one edge early or late shows up as a read mismatch. Writes to read-only and unimplemented addresses are followed by reads from both frames, which show that nothing moved.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

   // Each channel owns a 32-byte window: log2 of the span.
   localparam int WIN_LG = 5;

   // Offsets inside a channel window.
   localparam logic [4:0] OFS_STAT = 5'h00;
   localparam logic [4:0] OFS_CLR  = 5'h08;
   localparam logic [4:0] OFS_SET  = 5'h0C;

   // Frame-level register addresses.
   localparam logic [11:0] A_CAP = 12'hF80;
   localparam logic [11:0] A_REQ = 12'hF88;
   localparam logic [11:0] A_RDY = 12'hF8C;
   localparam logic [11:0] A_IEN = 12'hF98;
   localparam logic [11:0] A_ID  = 12'hFCC;

   // Bit position of the combined-interrupt enable.
   localparam int IEN_COMB_BIT = 2;

   typedef struct packed {
      logic cap;
      logic req;
      logic rdy;
      logic ien;
      logic id;
   } dbm_hit_t;

endpackage

// File: rtl/dbm_frame_dec.sv
module dbm_frame_dec
   import dbm_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 12
) (
   input  logic           sel,
   input  logic           wr,
   input  logic [AW-1:0]  addr,
   output logic [NCH-1:0] stat_rd,
   output logic [NCH-1:0] clr_wr,
   output logic [NCH-1:0] set_wr,
   output dbm_hit_t       rd_hit,
   output dbm_hit_t       wr_hit
);

   localparam int CW = AW - WIN_LG;

   if (AW < 12) begin : g_bad_aw
      $error("dbm_frame_dec: AW must reach the 0xFxx register block");
   end
   if ((NCH << WIN_LG) > int'(A_CAP)) begin : g_bad_nch
      $error("dbm_frame_dec: channel windows overlap the frame registers");
   end

   logic rd_en;
   logic wr_en;
   logic [WIN_LG-1:0] win_ofs;

   assign rd_en   = sel & ~wr;
   assign wr_en   = sel & wr;
   assign win_ofs = addr[WIN_LG-1:0];

   for (genvar n = 0; n < NCH; n++) begin : g_win
      logic in_win;
      assign in_win     = (addr[AW-1:WIN_LG] == CW'(n));
      assign stat_rd[n] = rd_en & in_win & (win_ofs == OFS_STAT);
      assign clr_wr[n]  = wr_en & in_win & (win_ofs == OFS_CLR);
      assign set_wr[n]  = wr_en & in_win & (win_ofs == OFS_SET);
   end

   dbm_hit_t hit;
   always_comb begin
      hit.cap = (addr == AW'(A_CAP));
      hit.req = (addr == AW'(A_REQ));
      hit.rdy = (addr == AW'(A_RDY));
      hit.ien = (addr == AW'(A_IEN));
      hit.id  = (addr == AW'(A_ID));
   end

   assign rd_hit = rd_en ? hit : '0;
   assign wr_hit = wr_en ? hit : '0;

endmodule

// File: rtl/dbm_stat_bank.sv
module dbm_stat_bank #(
   parameter int NCH = 4,
   parameter int DW  = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         set_en,
   input  logic [DW-1:0]          set_val,
   input  logic [NCH-1:0]         clr_a_en,
   input  logic [DW-1:0]          clr_a_val,
   input  logic [NCH-1:0]         clr_b_en,
   input  logic [DW-1:0]          clr_b_val,
   output logic [NCH-1:0][DW-1:0] status
);

   if (DW < 8) begin : g_bad_dw
      $error("dbm_stat_bank: DW too narrow for the register block");
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [DW-1:0] word;
      logic [DW-1:0] clr_mask;
      logic [DW-1:0] set_mask;
      logic          touch;

      assign clr_mask = (clr_a_en[n] ? clr_a_val : '0) | (clr_b_en[n] ? clr_b_val : '0);
      assign set_mask = set_en[n] ? set_val : '0;
      assign touch    = set_en[n] | clr_a_en[n] | clr_b_en[n];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word <= '0;
         end else if (touch) begin
            word <= (word & ~clr_mask) | set_mask;
         end
      end

      assign status[n] = word;

      // R1: every posted bit is present after the edge (set wins over clear)
      a_r1_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
         set_en[n] |=> ((status[n] & $past(set_val)) == $past(set_val)));

      // R2: an all-ones clear with no set empties the word
      a_r2_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_en[n] && ((clr_a_en[n] && (&clr_a_val)) || (clr_b_en[n] && (&clr_b_val))))
         |=> (status[n] == '0));
   end

endmodule

// File: rtl/dbm_access.sv
module dbm_access #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   input  logic req_bit,
   output logic req,
   output logic ready
);

   if (DLY < 1) begin : g_bad_dly
      $error("dbm_access: DLY must be at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else if (req_wr) begin
         req <= req_bit;
      end
   end

   if (DLY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ready <= 1'b0;
         else        ready <= req;
      end
   end else begin : g_line
      logic [DLY-1:0] line;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line <= '0;
         else        line <= {line[DLY-2:0], req};
      end
      assign ready = line[DLY-1];
   end

   // Cycles since the request last changed, saturating at DLY.
   localparam int HW = $clog2(DLY + 1) + 1;
   logic [HW-1:0] held;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= HW'(DLY);
      end else if (req_wr && (req_bit != req)) begin
         held <= '0;
      end else if (held < HW'(DLY)) begin
         held <= held + 1'b1;
      end
   end

   // R6: once the request has been steady for DLY edges, ready matches it
   a_r6_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (held >= HW'(DLY)) |-> (ready == req));

endmodule

// File: rtl/dbm_irq.sv
module dbm_irq #(
   parameter int NCH      = 4,
   parameter int DW       = 32,
   parameter bit HAS_COMB = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0][DW-1:0] status,
   input  logic                   ien_wr,
   input  logic                   ien_bit,
   output logic                   comb_en,
   output logic [NCH-1:0]         irq_ch,
   output logic                   irq_any
);

   for (genvar n = 0; n < NCH; n++) begin : g_line
      assign irq_ch[n] = |status[n];
   end

   if (HAS_COMB) begin : g_comb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            comb_en <= 1'b0;
         end else if (ien_wr) begin
            comb_en <= ien_bit;
         end
      end
      assign irq_any = comb_en & (|irq_ch);

      // R5: the enable takes the written bit on the next edge
      a_r5_en_write: assert property (@(posedge clk) disable iff (!rst_n)
         ien_wr |=> (comb_en == $past(ien_bit)));
   end else begin : g_nocomb
      logic unused_ien;
      assign unused_ien = ien_wr ^ ien_bit ^ clk ^ rst_n;
      assign comb_en    = 1'b0;
      assign irq_any    = 1'b0;
   end

endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
   import dbm_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DW        = 32,
   parameter int AW        = 12,
   parameter int RDY_DLY   = 2,
   parameter int REV_MINOR = 1,
   parameter int ID_MAJOR  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           s_sel,
   input  logic           s_wr,
   input  logic [AW-1:0]  s_addr,
   input  logic [DW-1:0]  s_wdata,
   output logic [DW-1:0]  s_rdata,
   input  logic           r_sel,
   input  logic           r_wr,
   input  logic [AW-1:0]  r_addr,
   input  logic [DW-1:0]  r_wdata,
   output logic [DW-1:0]  r_rdata,
   output logic [NCH-1:0] irq_ch,
   output logic           irq_any
);

   if ((NCH < 2) || ((NCH % 2) != 0)) begin : g_bad_nch
      $error("dbell_mbox: NCH must be nonzero and even");
   end
   if ((REV_MINOR < 0) || (REV_MINOR > 15) || (ID_MAJOR < 0) || (ID_MAJOR > 15)) begin : g_bad_rev
      $error("dbell_mbox: revision fields are four bits wide");
   end

   localparam bit         HAS_COMB = (REV_MINOR == 1);
   localparam logic [7:0] ID_VAL   = 8'((ID_MAJOR << 4) | REV_MINOR);

   // ---------------- decode ----------------
   logic [NCH-1:0] s_stat_rd, s_clr_wr, s_set_wr;
   logic [NCH-1:0] r_stat_rd, r_clr_wr, r_set_wr;
   dbm_hit_t       s_rd_hit, s_wr_hit, r_rd_hit, r_wr_hit;

   dbm_frame_dec #(.NCH(NCH), .AW(AW)) i_dec_s (
      .sel(s_sel), .wr(s_wr), .addr(s_addr),
      .stat_rd(s_stat_rd), .clr_wr(s_clr_wr), .set_wr(s_set_wr),
      .rd_hit(s_rd_hit), .wr_hit(s_wr_hit)
   );

   dbm_frame_dec #(.NCH(NCH), .AW(AW)) i_dec_r (
      .sel(r_sel), .wr(r_wr), .addr(r_addr),
      .stat_rd(r_stat_rd), .clr_wr(r_clr_wr), .set_wr(r_set_wr),
      .rd_hit(r_rd_hit), .wr_hit(r_wr_hit)
   );

   // ---------------- access handshake ----------------
   logic acc_req, acc_rdy;

   dbm_access #(.DLY(RDY_DLY)) i_acc (
      .clk(clk), .rst_n(rst_n),
      .req_wr(s_wr_hit.req), .req_bit(s_wdata[0]),
      .req(acc_req), .ready(acc_rdy)
   );

   // ---------------- status words ----------------
   logic [NCH-1:0][DW-1:0] status;
   logic [NCH-1:0]         set_en;

   assign set_en = s_set_wr & {NCH{acc_rdy}};

   dbm_stat_bank #(.NCH(NCH), .DW(DW)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_val(s_wdata),
      .clr_a_en(s_clr_wr), .clr_a_val(s_wdata),
      .clr_b_en(r_clr_wr), .clr_b_val(r_wdata),
      .status(status)
   );

   // ---------------- interrupts ----------------
   logic comb_en;

   dbm_irq #(.NCH(NCH), .DW(DW), .HAS_COMB(HAS_COMB)) i_irq (
      .clk(clk), .rst_n(rst_n), .status(status),
      .ien_wr(r_wr_hit.ien), .ien_bit(r_wdata[IEN_COMB_BIT]),
      .comb_en(comb_en), .irq_ch(irq_ch), .irq_any(irq_any)
   );

   // ---------------- read muxes ----------------
   always_comb begin
      s_rdata = '0;
      for (int n = 0; n < NCH; n++) begin
         if (s_stat_rd[n]) s_rdata = status[n];
      end
      if (s_rd_hit.cap) s_rdata = DW'(NCH);
      if (s_rd_hit.req) s_rdata = DW'(acc_req);
      if (s_rd_hit.rdy) s_rdata = DW'(acc_rdy);
      if (s_rd_hit.id)  s_rdata = DW'(ID_VAL);
   end

   always_comb begin
      r_rdata = '0;
      for (int n = 0; n < NCH; n++) begin
         if (r_stat_rd[n]) r_rdata = status[n];
      end
      if (r_rd_hit.ien) r_rdata = DW'(comb_en) << IEN_COMB_BIT;
      if (r_rd_hit.id)  r_rdata = DW'(ID_VAL);
   end

   // Decodes that this frame pairing does not use.
   logic unused_dec;
   assign unused_dec = ^{s_wr_hit.cap, s_wr_hit.rdy, s_wr_hit.ien, s_wr_hit.id,
                         s_rd_hit.ien, r_wr_hit.cap, r_wr_hit.req, r_wr_hit.rdy,
                         r_wr_hit.id, r_rd_hit.cap, r_rd_hit.req, r_rd_hit.rdy,
                         r_set_wr};

   // ---------------- assertions ----------------
   for (genvar n = 0; n < NCH; n++) begin : g_chk
      // R7: a gated-off set leaves the word alone
      a_r7_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (s_set_wr[n] && !acc_rdy && !s_clr_wr[n] && !r_clr_wr[n]) |=> $stable(status[n]));

      // R3: both frames see one word
      a_r3_same_word: assert property (@(posedge clk) disable iff (!rst_n)
         (s_stat_rd[n] && r_stat_rd[n]) |-> (s_rdata == r_rdata));
   end

   // R9: receiver writes to a set offset never raise a channel line
   a_r9_rx_set_inert: assert property (@(posedge clk) disable iff (!rst_n)
      ((|r_set_wr) && !s_sel && (irq_ch == '0)) |=> (irq_ch == '0));

endmodule

// File: tb/test_dbell_mbox.sv
module test_dbell_mbox;

   localparam int NCH = 4;
   localparam int DW  = 32;
   localparam int AW  = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           s_sel = 0, s_wr = 0, r_sel = 0, r_wr = 0;
   logic [AW-1:0]  s_addr = '0, r_addr = '0;
   logic [DW-1:0]  s_wdata = '0, r_wdata = '0;
   logic [DW-1:0]  s_rdata, r_rdata;
   logic [NCH-1:0] irq_ch;
   logic           irq_any;

   always #5 clk = ~clk;

   dbell_mbox #(.NCH(NCH), .DW(DW), .AW(AW)) i_dbell_mbox (
      .clk(clk), .rst_n(rst_n),
      .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .irq_ch(irq_ch), .irq_any(irq_any)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] m_stat [NCH];
   bit m_req, m_d1, m_rdy, m_comb;
   int total = 0, bad = 0;
   bit done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(bit rx, logic [11:0] a);
      int ch;
      ch = int'(a[11:5]);
      if (ch < NCH && a[4:0] == 5'h00) return m_stat[ch];
      if (a == 12'hFCC) return 32'h21;
      if (!rx && a == 12'hF80) return NCH;
      if (!rx && a == 12'hF88) return {31'b0, m_req};
      if (!rx && a == 12'hF8C) return {31'b0, m_rdy};
      if (rx && a == 12'hF98) return {29'b0, m_comb, 2'b0};
      return 32'h0;
   endfunction

   function automatic logic [NCH-1:0] m_irq();
      logic [NCH-1:0] v;
      for (int n = 0; n < NCH; n++) v[n] = (m_stat[n] != 0);
      return v;
   endfunction

   // One clock: check reads, take the edge, update the model, check lines.
   task automatic step(string tag);
      bit n_req;
      #2;
      if (s_sel && !s_wr) chk({tag, " sender read"}, s_rdata, m_read(0, s_addr));
      if (r_sel && !r_wr) chk({tag, " receiver read"}, r_rdata, m_read(1, r_addr));
      @(posedge clk);
      n_req = m_req;
      for (int n = 0; n < NCH; n++) begin
         logic [31:0] clr, st;
         clr = 0; st = 0;
         if (s_sel && s_wr && int'(s_addr[11:5]) == n && s_addr[4:0] == 5'h08) clr |= s_wdata;
         if (r_sel && r_wr && int'(r_addr[11:5]) == n && r_addr[4:0] == 5'h08) clr |= r_wdata;
         if (s_sel && s_wr && int'(s_addr[11:5]) == n && s_addr[4:0] == 5'h0C && m_rdy) st = s_wdata;
         m_stat[n] = (m_stat[n] & ~clr) | st;
      end
      if (s_sel && s_wr && s_addr == 12'hF88) n_req = s_wdata[0];
      if (r_sel && r_wr && r_addr == 12'hF98) m_comb = r_wdata[2];
      m_rdy = m_d1;
      m_d1  = m_req;
      m_req = n_req;
      #1;
      chk("R4 irq_ch", 32'(irq_ch), 32'(m_irq()));
      chk("R5 irq_any", 32'(irq_any), 32'(m_comb && (m_irq() != 0)));
      s_sel = 0; s_wr = 0; r_sel = 0; r_wr = 0;
   endtask

   task automatic sw(logic [11:0] a, logic [31:0] d, string tag);
      s_sel = 1; s_wr = 1; s_addr = a; s_wdata = d; step(tag);
   endtask
   task automatic sr(logic [11:0] a, string tag);
      s_sel = 1; s_wr = 0; s_addr = a; step(tag);
   endtask
   task automatic rw(logic [11:0] a, logic [31:0] d, string tag);
      r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d; step(tag);
   endtask
   task automatic rr(logic [11:0] a, string tag);
      r_sel = 1; r_wr = 0; r_addr = a; step(tag);
   endtask
   task automatic both_rd(logic [11:0] a, string tag);
      s_sel = 1; s_wr = 0; s_addr = a; r_sel = 1; r_wr = 0; r_addr = a; step(tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < NCH; n++) m_stat[n] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R10: reset state
      for (int n = 0; n < NCH; n++) both_rd(12'(n * 32), "R10 status");
      sr(12'hF88, "R10 request");
      sr(12'hF8C, "R10 ready");
      rr(12'hF98, "R10 enable");

      // R8: capability and identification, then write attempts
      sr(12'hF80, "R8 capability");
      both_rd(12'hFCC, "R8 id");
      sw(12'hF80, 32'hFFFF_FFFF, "R8 cap write");
      sw(12'hFCC, 32'h0, "R8 id write");
      rw(12'hFCC, 32'h0, "R8 id write rx");
      sr(12'hF80, "R8 capability after write");
      both_rd(12'hFCC, "R8 id after write");

      // R7: posting before access is granted
      sw(12'h020 + 12'h0C, 32'h0000_0001, "R7 early set");
      both_rd(12'h020, "R7 early set dropped");

      // R6: request up, watch ready each cycle
      sw(12'hF88, 32'h1, "R6 request");
      sr(12'hF8C, "R6 ready edge1");
      sr(12'hF8C, "R6 ready edge2");
      sr(12'hF88, "R6 request readback");

      // R1: single bits and masks, merged
      sw(12'h00C, 32'h0000_0005, "R1 set ch0");
      sw(12'h00C, 32'h0000_0030, "R1 set ch0 again");
      both_rd(12'h000, "R1 ch0 merged");
      sw(12'h06C, 32'h8000_0000, "R1 set ch3 top");

      // R3: window decoding on every channel, both frames
      for (int n = 0; n < NCH; n++) both_rd(12'(n * 32), "R3 window");

      // R2: clears from each frame, then set and clear in one cycle
      rw(12'h008, 32'h0000_0001, "R2 rx clear");
      sw(12'h008, 32'h0000_0004, "R2 tx clear");
      rr(12'h000, "R2 ch0 after clears");
      s_sel = 1; s_wr = 1; s_addr = 12'h04C; s_wdata = 32'h3;
      r_sel = 1; r_wr = 1; r_addr = 12'h048; r_wdata = 32'h1;
      step("R2 set+clear same cycle");
      both_rd(12'h040, "R2 set wins");

      // R5: combined interrupt enable
      rw(12'hF98, 32'h0000_0004, "R5 enable on");
      rr(12'hF98, "R5 enable readback");
      rw(12'hF98, 32'hFFFF_FFFB, "R5 enable off");
      rr(12'hF98, "R5 enable cleared");
      rw(12'hF98, 32'hFFFF_FFFF, "R5 enable on again");
      rr(12'hF98, "R5 other bits zero");

      // R9: unimplemented and frame-mismatched addresses
      rw(12'h02C, 32'hFFFF_FFFF, "R9 rx set");
      both_rd(12'h020, "R9 rx set inert");
      sw(12'hF98, 32'h0, "R9 tx enable write");
      rr(12'hF98, "R9 enable kept");
      rw(12'hF88, 32'h0, "R9 rx request write");
      sr(12'hF88, "R9 request kept");
      sw(12'h004, 32'hFFFF_FFFF, "R9 hole write");
      both_rd(12'h000, "R9 hole write inert");
      sr(12'h004, "R9 hole read");
      sr(12'h100, "R9 beyond channels");
      sr(12'hF90, "R9 gap read");
      rr(12'hF80, "R9 rx capability");
      rr(12'hF8C, "R9 rx ready");

      // R4: drain everything, interrupts fall
      for (int n = 0; n < NCH; n++) rw(12'(n * 32 + 8), 32'hFFFF_FFFF, "R4 drain");
      both_rd(12'h060, "R4 ch3 empty");

      // R6/R7: release access, ready falls two edges later, sets dropped again
      sw(12'hF88, 32'h0, "R6 release");
      sw(12'h00C, 32'h0000_0100, "R7 set during fall edge1");
      sr(12'hF8C, "R6 ready falls");
      sw(12'h00C, 32'h0000_0200, "R7 set after fall");
      both_rd(12'h000, "R7 late sets");

      // R6: one-cycle request pulse
      sw(12'hF88, 32'h1, "R6 pulse up");
      sw(12'hF88, 32'h0, "R6 pulse down");
      sr(12'hF8C, "R6 pulse ready");
      sr(12'hF8C, "R6 pulse ready next");
      sr(12'hF8C, "R6 pulse ready settled");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule